// File: doc/BRIEF.md
# Power-Down, Suspend and Output-Gate Controller

This block decides which frequency-synthesis loops (PLLs) run and which clock outputs drive, based on two active-low control pins and a static configuration. The main control pin works in one of two modes chosen by a configuration bit. In full power-down mode a low level stops every PLL and disables every output. In gate-only mode the same low level only disables the outputs, and the PLLs keep running. A second active-low pin, the suspend pin, stops the PLLs and outputs that two configuration masks name. A disabled output is driven low.

Each output has a source code that names the PLL it is derived from. A code of 0 to NUM_PLL-1 selects that PLL. Any higher code, for example 3 with the default three PLLs, selects the reference oscillator, which has no lock dependency. After a PLL is enabled, it has to run for a number of timebase ticks before its lock-valid flag is set: the CPU PLL (index 0) needs the long count and the other PLLs need the short count. An output stays disabled until the PLL it depends on is marked locked.

The block also checks the suspend masks against the output source map. It flags any output that would be left enabled while its source PLL is suspended, and it forces that output off anyway.

Top module: `sso_power_gate`

## Requirements
- R1: With the mode bit at 1 (full power-down), a low on the main control pin clears every PLL enable, every lock-valid flag and every output enable.
- R2: With the mode bit at 0 (gate-only), a low on the main control pin clears every output enable while the PLL enables and lock-valid flags keep their values. When the pin returns high, the outputs come back without any timebase tick.
- R3: While the suspend pin is low, each PLL whose bit is 1 in the suspend PLL mask is disabled and each output whose bit is 1 in the suspend output mask is disabled. PLLs and outputs whose mask bits are 0 are unaffected.
- R4: The configuration-error flag is 1 whenever some output with source code below NUM_PLL maps to a PLL whose suspend PLL mask bit is 1 while that output's suspend output mask bit is 0. The flag does not depend on the pin levels. While the suspend pin is low, such an output is disabled.
- R5: A PLL's lock-valid flag is set only after LOCK_LONG timebase ticks for PLL 0, or LOCK_SHORT ticks for any other PLL, counted while the PLL is enabled. Ticks that arrive while the PLL is disabled are not counted.
- R6: An output with source code below NUM_PLL is enabled only while that PLL's lock-valid flag is set. An output with a higher source code (the reference) needs no lock.
- R7: Disabling a PLL discards any partial tick count, so a PLL that is enabled again needs the full tick count.
- R8: During reset all PLL enables, lock-valid flags, output enables and the error flag are 0. While the suspend pin is high, the suspend masks have no effect on any enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| shutOeN | input | 1 | Main control pin, active low |
| suspendN | input | 1 | Suspend pin, active low |
| shutMode | input | 1 | 1 = full power-down, 0 = gate outputs only |
| tick | input | 1 | Timebase strobe for the lock timers |
| suspPllMask | input | NUM_PLL | PLLs stopped during suspend |
| suspOutMask | input | NUM_OUT | Outputs disabled during suspend |
| srcMap | input | NUM_OUT*SRC_W | Source code per output; field o sits at bits [o*SRC_W +: SRC_W] |
| pllEn | output | NUM_PLL | PLL run enables |
| lockValid | output | NUM_PLL | PLL lock-valid flags |
| outEn | output | NUM_OUT | Output enables (0 = driven low) |
| cfgErr | output | 1 | Suspend masks inconsistent with the source map |

## Verification
The bench probes the lock timer one tick short of each limit and then exactly at the limit. A design that is off by one tick, or that treats the CPU PLL like the others, shows an early or late lock flag there. It also feeds ticks while a PLL is powered down, and it interrupts a partial relock. A timer that counts while disabled, or that keeps a partial count, then locks too early. The gate-only case checks that the PLLs stay running and the outputs return at once, which a design that merged the two modes would fail. An inconsistent mask pair checks that the dependent output is forced off and the error flag is set even while the suspend pin is high.

// File: rtl/sso_pkg.sv
package sso_pkg;
  // Strobes sent from the control to the datapath each cycle.
  typedef struct packed {
    logic shutOn;       // full power-down active
    logic outsAllowed;  // main pin high, outputs may drive
    logic suspOn;       // suspend pin low
    logic tickQ;        // registered timebase tick
  } sso_strobe_t;
endpackage

// File: rtl/sso_ctrl.sv
module sso_ctrl
  import sso_pkg::*;
#(
  parameter int NUM_PLL = 3,
  parameter int NUM_OUT = 6,
  parameter int SRC_W   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     shutOeN,
  input  logic                     suspendN,
  input  logic                     shutMode,
  input  logic                     tick,
  input  logic [NUM_PLL-1:0]       suspPllMask,
  input  logic [NUM_OUT-1:0]       suspOutMask,
  input  logic [NUM_OUT*SRC_W-1:0] srcMap,
  output sso_strobe_t              strb,
  output logic                     cfgErr
);
  logic errNext;

  // Static consistency check between the masks and the source map.
  always_comb begin
    errNext = 1'b0;
    for (int o = 0; o < NUM_OUT; o++) begin
      if (int'(srcMap[o*SRC_W +: SRC_W]) < NUM_PLL) begin
        if (suspPllMask[srcMap[o*SRC_W +: SRC_W]] && !suspOutMask[o]) errNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strb   <= '{shutOn: 1'b1, outsAllowed: 1'b0, suspOn: 1'b0, tickQ: 1'b0};
      cfgErr <= 1'b0;
    end else begin
      strb.shutOn      <= !shutOeN && shutMode;
      strb.outsAllowed <= shutOeN;
      strb.suspOn      <= !suspendN;
      strb.tickQ       <= tick;
      cfgErr           <= errNext;
    end
  end

  // R1: power-down never coexists with outputs allowed
  a_r1_shut_blocks_outs: assert property (@(posedge clk) disable iff (!rstN)
    strb.shutOn |-> !strb.outsAllowed);
endmodule

// File: rtl/sso_datapath.sv
module sso_datapath
  import sso_pkg::*;
#(
  parameter int NUM_PLL    = 3,
  parameter int NUM_OUT    = 6,
  parameter int SRC_W      = 2,
  parameter int LOCK_LONG  = 50,
  parameter int LOCK_SHORT = 4,
  parameter int CNT_W      = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sso_strobe_t              strb,
  input  logic [NUM_PLL-1:0]       suspPllMask,
  input  logic [NUM_OUT-1:0]       suspOutMask,
  input  logic [NUM_OUT*SRC_W-1:0] srcMap,
  output logic [NUM_PLL-1:0]       pllEn,
  output logic [NUM_PLL-1:0]       lockValid,
  output logic [NUM_OUT-1:0]       outEn
);
  // One lock timer per PLL; PLL 0 takes the long window.
  for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
    localparam int LIM = (p == 0) ? LOCK_LONG : LOCK_SHORT;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pllEn[p] <= 1'b0;
        cnt      <= '0;
      end else begin
        pllEn[p] <= !strb.shutOn && !(strb.suspOn && suspPllMask[p]);
        if (!pllEn[p]) cnt <= '0;
        else if (strb.tickQ && cnt != CNT_W'(LIM)) cnt <= cnt + CNT_W'(1);
      end
    end

    assign lockValid[p] = pllEn[p] && (cnt == CNT_W'(LIM));

    // R5: timer never passes its limit
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= CNT_W'(LIM));
    // R7: a disabled PLL loses its partial count
    a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
      !pllEn[p] |=> cnt == '0);
    // R1: power-down stops the PLL on the next edge
    a_r1_shut_pll_off: assert property (@(posedge clk) disable iff (!rstN)
      strb.shutOn |=> !pllEn[p]);
  end

  // Output gating: pins, suspend masks, source dependency, lock.
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [SRC_W-1:0] src;
    logic isPll, suspHit, locked;

    assign src     = srcMap[o*SRC_W +: SRC_W];
    assign isPll   = int'(src) < NUM_PLL;
    assign suspHit = strb.suspOn && (suspOutMask[o] || (isPll && suspPllMask[src]));
    assign locked  = isPll ? lockValid[src] : 1'b1;

    always_ff @(posedge clk) begin
      if (!rstN) outEn[o] <= 1'b0;
      else       outEn[o] <= strb.outsAllowed && !suspHit && locked;
    end

    // R4: an enabled PLL-derived output always has its PLL running
    a_r4_out_needs_pll: assert property (@(posedge clk) disable iff (!rstN)
      (outEn[o] && isPll) |-> pllEn[src]);
    // R2: a low main pin drops the output on the next edge
    a_r2_gate_off: assert property (@(posedge clk) disable iff (!rstN)
      !strb.outsAllowed |=> !outEn[o]);
  end
endmodule

// File: rtl/sso_power_gate.sv
module sso_power_gate
  import sso_pkg::*;
#(
  parameter int NUM_PLL    = 3,
  parameter int NUM_OUT    = 6,
  parameter int LOCK_LONG  = 50,
  parameter int LOCK_SHORT = 4,
  localparam int SRC_W     = $clog2(NUM_PLL + 1),
  localparam int CNT_W     = $clog2(LOCK_LONG + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     shutOeN,
  input  logic                     suspendN,
  input  logic                     shutMode,
  input  logic                     tick,
  input  logic [NUM_PLL-1:0]       suspPllMask,
  input  logic [NUM_OUT-1:0]       suspOutMask,
  input  logic [NUM_OUT*SRC_W-1:0] srcMap,
  output logic [NUM_PLL-1:0]       pllEn,
  output logic [NUM_PLL-1:0]       lockValid,
  output logic [NUM_OUT-1:0]       outEn,
  output logic                     cfgErr
);
  sso_strobe_t strb;

  sso_ctrl #(.NUM_PLL(NUM_PLL), .NUM_OUT(NUM_OUT), .SRC_W(SRC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .shutOeN(shutOeN), .suspendN(suspendN),
    .shutMode(shutMode), .tick(tick), .suspPllMask(suspPllMask),
    .suspOutMask(suspOutMask), .srcMap(srcMap), .strb(strb), .cfgErr(cfgErr)
  );

  sso_datapath #(
    .NUM_PLL(NUM_PLL), .NUM_OUT(NUM_OUT), .SRC_W(SRC_W),
    .LOCK_LONG(LOCK_LONG), .LOCK_SHORT(LOCK_SHORT), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .suspPllMask(suspPllMask),
    .suspOutMask(suspOutMask), .srcMap(srcMap), .pllEn(pllEn),
    .lockValid(lockValid), .outEn(outEn)
  );
endmodule

// File: tb/tb_sso_power_gate.sv
module tb_sso_power_gate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shutOeN = 1'b1, suspendN = 1'b1, shutMode = 1'b1, tick = 1'b0;
  logic [2:0]  suspPllMask = '0;
  logic [5:0]  suspOutMask = '0;
  // out0->PLL0, out1->PLL1, out2->PLL2, out3->PLL1, out4->reference(code 3), out5->PLL2
  logic [11:0] srcMap = {2'd2, 2'd3, 2'd1, 2'd2, 2'd1, 2'd0};
  logic [2:0]  pllEn, lockValid;
  logic [5:0]  outEn;
  logic        cfgErr;

  int testsRun = 0, testsFailed = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] pll;
    logic [2:0] lock;
    logic [5:0] out;
    logic       err;
    string      tag;
  } exp_t;
  exp_t sbQ[$];

  always #2 clk = ~clk;

  sso_power_gate #(.NUM_PLL(3), .NUM_OUT(6), .LOCK_LONG(50), .LOCK_SHORT(4)) dut (
    .clk(clk), .rstN(rstN), .shutOeN(shutOeN), .suspendN(suspendN),
    .shutMode(shutMode), .tick(tick), .suspPllMask(suspPllMask),
    .suspOutMask(suspOutMask), .srcMap(srcMap), .pllEn(pllEn),
    .lockValid(lockValid), .outEn(outEn), .cfgErr(cfgErr)
  );

  // Monitor: pops expected items and compares them away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        exp_t e;
        e = sbQ.pop_front();
        testsRun++;
        if (pllEn !== e.pll || lockValid !== e.lock || outEn !== e.out || cfgErr !== e.err) begin
          testsFailed++;
          $display("FAIL %s: pll=%b lock=%b out=%b err=%b expected pll=%b lock=%b out=%b err=%b",
                   e.tag, pllEn, lockValid, outEn, cfgErr, e.pll, e.lock, e.out, e.err);
        end
      end
    end
  end

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic expectNow(input logic [2:0] p, input logic [2:0] l,
                           input logic [5:0] o, input logic e, input string tag);
    exp_t item;
    settle();
    item.pll = p; item.lock = l; item.out = o; item.err = e; item.tag = tag;
    sbQ.push_back(item);
    wait (sbQ.size() == 0);
  endtask

  task automatic giveTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    expectNow(3'b000, 3'b000, 6'b000000, 1'b0, "R8 reset");
    @(negedge clk) rstN = 1'b1;
    // R6: only the reference-sourced output runs before any lock
    expectNow(3'b111, 3'b000, 6'b010000, 1'b0, "R6 ref needs no lock");
    giveTicks(4);
    expectNow(3'b111, 3'b110, 6'b111110, 1'b0, "R5 short lock at limit");
    giveTicks(45);
    expectNow(3'b111, 3'b110, 6'b111110, 1'b0, "R5 long lock one short");
    giveTicks(1);
    expectNow(3'b111, 3'b111, 6'b111111, 1'b0, "R5 long lock at limit");

    // R2: gate-only mode
    @(negedge clk) begin shutMode = 1'b0; shutOeN = 1'b0; end
    expectNow(3'b111, 3'b111, 6'b000000, 1'b0, "R2 gate keeps PLLs");
    @(negedge clk) shutOeN = 1'b1;
    expectNow(3'b111, 3'b111, 6'b111111, 1'b0, "R2 no relock");

    // R1: full power-down
    @(negedge clk) begin shutMode = 1'b1; shutOeN = 1'b0; end
    expectNow(3'b000, 3'b000, 6'b000000, 1'b0, "R1 power-down");
    giveTicks(5);
    expectNow(3'b000, 3'b000, 6'b000000, 1'b0, "R5 ticks while off");
    @(negedge clk) shutOeN = 1'b1;
    expectNow(3'b111, 3'b000, 6'b010000, 1'b0, "R1 relock required");
    giveTicks(4);
    expectNow(3'b111, 3'b110, 6'b111110, 1'b0, "R1 short relock");
    giveTicks(46);
    expectNow(3'b111, 3'b111, 6'b111111, 1'b0, "R1 long relock");

    // R3: consistent suspend of PLL2 and its outputs plus the reference output
    @(negedge clk) begin suspPllMask = 3'b100; suspOutMask = 6'b110100; end
    expectNow(3'b111, 3'b111, 6'b111111, 1'b0, "R8 masks idle while pin high");
    @(negedge clk) suspendN = 1'b0;
    expectNow(3'b011, 3'b011, 6'b001011, 1'b0, "R3 suspend set");
    @(negedge clk) suspendN = 1'b1;
    expectNow(3'b111, 3'b011, 6'b011011, 1'b0, "R6 wait for relock");
    giveTicks(4);
    expectNow(3'b111, 3'b111, 6'b111111, 1'b0, "R3 resume");

    // R4: inconsistent masks
    @(negedge clk) begin suspPllMask = 3'b010; suspOutMask = 6'b000000; end
    expectNow(3'b111, 3'b111, 6'b111111, 1'b1, "R4 error flag static");
    @(negedge clk) suspendN = 1'b0;
    expectNow(3'b101, 3'b101, 6'b110101, 1'b1, "R4 dependent outputs forced off");
    @(negedge clk) suspendN = 1'b1;
    giveTicks(4);
    expectNow(3'b111, 3'b111, 6'b111111, 1'b1, "R4 resume");

    // R7: interrupted relock restarts from zero
    @(negedge clk) begin suspPllMask = 3'b010; suspOutMask = 6'b001010; end
    @(negedge clk) suspendN = 1'b0;
    settle();
    @(negedge clk) suspendN = 1'b1;
    settle();
    giveTicks(2);
    @(negedge clk) suspendN = 1'b0;
    settle();
    @(negedge clk) suspendN = 1'b1;
    settle();
    giveTicks(3);
    expectNow(3'b111, 3'b101, 6'b110101, 1'b0, "R7 partial count lost");
    giveTicks(1);
    expectNow(3'b111, 3'b111, 6'b111111, 1'b0, "R7 full count");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule